// File: doc/BRIEF.md
# Interrupt Status and Summary Controller

This block gathers single-cycle event pulses from the transmit, receive, link, timer, bus-error and wake-up logic of a network controller. It holds them as sticky bits in one 32-bit status word, next to a three-bit fatal bus error code and the live transmit and receive process states. Two summary bits are derived from the status word. One covers the normal events and one covers the abnormal events. A mask word at the same bit positions gates each source, and two of its bits enable the two groups. The result drives a single active-low interrupt request.

Software uses a small register port. Address 0 holds the status word, and writing ones there clears the matching event bits. Address 1 holds the mask word. Two events clear a partner event automatically: transmit done clears early transmit, and link fail clears link pass.

Top module: `irq_status_ctrl`

## Requirements
- R1: After a synchronous reset, the status word, the error code and the mask word are all zero, `irq_n` is 1, and a read returns zero at both addresses when the process state inputs are zero.
- R2: A pulse on `evt_i[k]` sets status bit k at that clock edge. This holds for k in 0..14, 27 and 28. The bit then stays set with no further pulse. A pulse at any other position has no effect.
- R3: Writing to address 0 clears each event bit whose write-data bit is 1. Write-data bits that are 0 leave their event bits unchanged. If a clear and a new event hit the same bit in the same cycle, the bit stays set.
- R4: Status bit 16 reads as the OR of status bits 0, 2, 6 and 28. Status bit 15 reads as the OR of status bits 1, 3, 5, 7, 8, 9, 10, 11, 13 and 27. Neither summary bit depends on the mask.
- R5: A transmit-done event (bit 0) clears early transmit (bit 10) at the same edge. This applies even when an early-transmit pulse arrives in that same cycle.
- R6: A link-fail event (bit 12) clears link pass (bit 4) at the same edge. This applies even when a link-pass pulse arrives in that same cycle.
- R7: A fatal bus error event (bit 13) captures `err_code_i` into status bits 25:23. The codes are 0 for a parity error, 1 for a master abort and 2 for a target abort; other codes are reserved. The field reads zero whenever bit 13 is clear.
- R8: Status bits 22:20 show `tx_state_i` and bits 19:17 show `rx_state_i`. Writes to address 0 do not change these fields.
- R9: The mask word at address 1 keeps only bits 0..16, 27 and 28. All its other bits read as 0.
- R10: `irq_n` is 0 exactly when one of two conditions holds. Either mask bit 16 is set and a normal-group status bit with its mask bit set is set, or mask bit 15 is set and an abnormal-group status bit with its mask bit set is set. `irq_n` follows at the same edge that changes the status or the mask. Bits 4, 12 and 14 never raise it.
- R11: `reg_rdata` is registered. It shows the word at `reg_addr` as it stood before the edge that loads `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 32 | Single-cycle event pulses, one per status bit position |
| err_code_i | input | 3 | Fatal bus error code, sampled with the fatal event |
| tx_state_i | input | 3 | Transmit process state |
| rx_state_i | input | 3 | Receive process state |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects mask |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest cases are same-cycle collisions, because they only arise when the bench lines up two inputs in one clock cycle. One collision is a write-one-to-clear landing in the same cycle as a fresh pulse on that bit. Another is transmit done arriving with early transmit, and another is link fail arriving with link pass. The bench drives both inputs on the same falling edge and reads the status word afterwards. For interrupt gating, it walks the mask through a group-disabled setting and a source-masked setting while a status bit stays pending, and it checks that `irq_n` follows each mask write.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DW = 32;
  localparam int PS_W = 3;
  localparam int EC_W = 3;

  localparam int B_TXDONE = 0;
  localparam int B_LPASS  = 4;
  localparam int B_TXERLY = 10;
  localparam int B_LFAIL  = 12;
  localparam int B_FATAL  = 13;
  localparam int B_ABN    = 15;
  localparam int B_NORM   = 16;
  localparam int RXS_LO   = 17;
  localparam int TXS_LO   = RXS_LO + PS_W;
  localparam int ERR_LO   = TXS_LO + PS_W;

  localparam logic [DW-1:0] EV_BITS   = 32'h1800_7FFF;
  localparam logic [DW-1:0] NORM_BITS = 32'h1000_0045;
  localparam logic [DW-1:0] ABN_BITS  = 32'h0800_2FAA;
  localparam logic [DW-1:0] MASK_WR   = EV_BITS | (32'h1 << B_ABN) | (32'h1 << B_NORM);
endpackage

// File: rtl/irq_sticky_reg.sv
module irq_sticky_reg
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   set_i,
  input  logic [DW-1:0]   clr_i,
  input  logic [EC_W-1:0] code_i,
  output logic [DW-1:0]   stat_q,
  output logic [DW-1:0]   stat_d,
  output logic [EC_W-1:0] code_q
);
  logic [DW-1:0]   auto_clr;
  logic [EC_W-1:0] code_d;

  always_comb begin
    auto_clr = '0;
    auto_clr[B_TXERLY] = set_i[B_TXDONE];
    auto_clr[B_LPASS]  = set_i[B_LFAIL];
    stat_d = (((stat_q & ~clr_i) | set_i) & ~auto_clr) & EV_BITS;
    if (set_i[B_FATAL])
      code_d = code_i;
    else if (stat_d[B_FATAL])
      code_d = code_q;
    else
      code_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      code_q <= '0;
    end else begin
      stat_q <= stat_d;
      code_q <= code_d;
    end
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_pkg::*;
(
  input  logic [DW-1:0] stat_i,
  input  logic [DW-1:0] mask_i,
  output logic          norm_o,
  output logic          abn_o,
  output logic          pend_o
);
  logic [DW-1:0] norm_hit;
  logic [DW-1:0] abn_hit;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign norm_hit[i] = NORM_BITS[i] & stat_i[i];
    assign abn_hit[i]  = ABN_BITS[i] & stat_i[i];
  end

  assign norm_o = |norm_hit;
  assign abn_o  = |abn_hit;
  assign pend_o = (mask_i[B_NORM] & |(norm_hit & mask_i)) |
                  (mask_i[B_ABN]  & |(abn_hit  & mask_i));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   evt_i,
  input  logic [EC_W-1:0] err_code_i,
  input  logic [PS_W-1:0] tx_state_i,
  input  logic [PS_W-1:0] rx_state_i,
  input  logic            reg_wr,
  input  logic            reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_n
);
  logic [DW-1:0]   stat_q, stat_d, clr, mask_q, mask_d, view;
  logic [EC_W-1:0] code_q;
  logic            norm_q, abn_q, pend_q_unused, norm_d_unused, abn_d_unused, pend_d;

  assign clr    = (reg_wr && !reg_addr) ? (reg_wdata & EV_BITS) : '0;
  assign mask_d = (reg_wr && reg_addr) ? (reg_wdata & MASK_WR) : mask_q;

  irq_sticky_reg i_sticky (
    .clk(clk), .rst(rst), .set_i(evt_i & EV_BITS), .clr_i(clr),
    .code_i(err_code_i), .stat_q(stat_q), .stat_d(stat_d), .code_q(code_q)
  );

  irq_summary i_sum_now (
    .stat_i(stat_q), .mask_i(mask_q),
    .norm_o(norm_q), .abn_o(abn_q), .pend_o(pend_q_unused)
  );

  irq_summary i_sum_next (
    .stat_i(stat_d), .mask_i(mask_d),
    .norm_o(norm_d_unused), .abn_o(abn_d_unused), .pend_o(pend_d)
  );

  always_comb begin
    view = stat_q;
    view[B_NORM] = norm_q;
    view[B_ABN]  = abn_q;
    view[RXS_LO +: PS_W] = rx_state_i;
    view[TXS_LO +: PS_W] = tx_state_i;
    view[ERR_LO +: EC_W] = code_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      irq_n     <= 1'b1;
      reg_rdata <= '0;
    end else begin
      mask_q    <= mask_d;
      irq_n     <= ~pend_d;
      reg_rdata <= reg_addr ? mask_q : view;
    end
  end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [DW-1:0]   evt_i,
  input logic [EC_W-1:0] err_code_i,
  input logic            reg_wr,
  input logic            reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic [DW-1:0]   stat_q,
  input logic [DW-1:0]   mask_q,
  input logic [EC_W-1:0] code_q,
  input logic            irq_n
);
  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    evt_i[6] |=> stat_q[6]);

  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_addr && reg_wdata[7] && !evt_i[7]) |=> !stat_q[7]);

  a_r3_event_wins: assert property (@(posedge clk) disable iff (rst)
    (evt_i[7] && reg_wr && !reg_addr && reg_wdata[7]) |=> stat_q[7]);

  a_r5_txdone_clears_early: assert property (@(posedge clk) disable iff (rst)
    evt_i[B_TXDONE] |=> (stat_q[B_TXDONE] && !stat_q[B_TXERLY]));

  a_r6_lfail_clears_lpass: assert property (@(posedge clk) disable iff (rst)
    evt_i[B_LFAIL] |=> (stat_q[B_LFAIL] && !stat_q[B_LPASS]));

  a_r7_code_capture: assert property (@(posedge clk) disable iff (rst)
    evt_i[B_FATAL] |=> (code_q == $past(err_code_i)));

  a_r10_irq_needs_group: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> (mask_q[B_NORM] || mask_q[B_ABN]));
endmodule

bind irq_status_ctrl irq_status_chk i_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .err_code_i(err_code_i),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .stat_q(stat_q), .mask_q(mask_q), .code_q(code_q), .irq_n(irq_n)
);

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] evt_i = '0;
  logic [2:0]  err_code_i = '0;
  logic [2:0]  tx_state_i = '0;
  logic [2:0]  rx_state_i = '0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_n;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_status_ctrl i_irq_status_ctrl (
    .clk(clk), .rst(rst), .evt_i(evt_i), .err_code_i(err_code_i),
    .tx_state_i(tx_state_i), .rx_state_i(rx_state_i), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_n(irq_n)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [31:0] ev);
    @(negedge clk) evt_i = ev;
    @(negedge clk) evt_i = '0;
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk) begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
    @(negedge clk) reg_wr = 1'b0;
  endtask

  task automatic rd(logic a, output logic [31:0] d);
    @(negedge clk) reg_addr = a;
    @(negedge clk) d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(1'b0, d); check("R1 status", d, 32'h0);
    rd(1'b1, d); check("R1 mask", d, 32'h0);
    check("R1 irq_n", {31'b0, irq_n}, 32'h1);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    pulse(32'h40);
    rd(1'b0, d); check("R2 rx done sticky + R4 normal", d, 32'h0001_0040);
    pulse(32'h8000_0000);
    rd(1'b0, d); check("R2 undefined ignored", d, 32'h0001_0040);
    pulse(32'h80);
    rd(1'b0, d); check("R11 R4 abnormal summary", d, 32'h0001_80C0);
    pulse(32'h1000_0000);
    rd(1'b0, d); check("R2 wake bit 28", d, 32'h1001_80C0);
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, d); check("R3 clear all", d, 32'h0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    pulse(32'h0C);
    wr(1'b0, 32'h04);
    rd(1'b0, d); check("R3 selective clear", d, 32'h0000_8008);
    wr(1'b0, 32'h0);
    rd(1'b0, d); check("R3 zero write", d, 32'h0000_8008);
    @(negedge clk) begin evt_i = 32'h08; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h08; end
    @(negedge clk) begin evt_i = '0; reg_wr = 1'b0; end
    rd(1'b0, d); check("R3 event wins over clear", d, 32'h0000_8008);
    wr(1'b0, 32'hFFFF_FFFF);
  endtask

  task automatic t_autoclr;
    logic [31:0] d;
    pulse(32'h400);
    rd(1'b0, d); check("R5 early set", d, 32'h0000_8400);
    pulse(32'h1);
    rd(1'b0, d); check("R5 tx done clears early", d, 32'h0001_0001);
    wr(1'b0, 32'hFFFF_FFFF);
    pulse(32'h401);
    rd(1'b0, d); check("R5 same cycle", d, 32'h0001_0001);
    wr(1'b0, 32'hFFFF_FFFF);
    pulse(32'h10);
    pulse(32'h1000);
    rd(1'b0, d); check("R6 link fail clears pass", d, 32'h0000_1000);
    wr(1'b0, 32'hFFFF_FFFF);
    pulse(32'h1010);
    rd(1'b0, d); check("R6 same cycle", d, 32'h0000_1000);
    wr(1'b0, 32'hFFFF_FFFF);
  endtask

  task automatic t_errcode;
    logic [31:0] d;
    err_code_i = 3'd2;
    pulse(32'h2000);
    err_code_i = 3'd0;
    rd(1'b0, d); check("R7 target abort code", d, 32'h0100_A000);
    err_code_i = 3'd1;
    pulse(32'h2000);
    rd(1'b0, d); check("R7 master abort code", d, 32'h0080_A000);
    wr(1'b0, 32'h2000);
    rd(1'b0, d); check("R7 code cleared", d, 32'h0);
    err_code_i = 3'd0;
  endtask

  task automatic t_state;
    logic [31:0] d;
    tx_state_i = 3'd5; rx_state_i = 3'd3;
    rd(1'b0, d); check("R8 states", d, 32'h0056_0000);
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, d); check("R8 not writable", d, 32'h0056_0000);
    tx_state_i = 3'd0; rx_state_i = 3'd0;
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, d); check("R9 mask bits", d, 32'h1801_FFFF);
    check("R10 idle", {31'b0, irq_n}, 32'h1);
    pulse(32'h10);
    check("R10 link pass no irq", {31'b0, irq_n}, 32'h1);
    pulse(32'h40);
    check("R10 normal irq", {31'b0, irq_n}, 32'h0);
    wr(1'b1, 32'h1800_FFFF);
    check("R10 normal group off", {31'b0, irq_n}, 32'h1);
    wr(1'b1, 32'h1801_FFBF);
    check("R10 source masked", {31'b0, irq_n}, 32'h1);
    pulse(32'h20);
    check("R10 abnormal irq", {31'b0, irq_n}, 32'h0);
    wr(1'b0, 32'hFFFF_FFFF);
    check("R10 cleared", {31'b0, irq_n}, 32'h1);
    wr(1'b1, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sticky();
    t_w1c();
    t_autoclr();
    t_errcode();
    t_state();
    t_mask();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule